// File: doc/BRIEF.md
# Residue Inner-Product Pipeline

This block computes inner products over the ring of integers modulo a small modulus (3, 5 or 7, set by a parameter). It serves one residue channel of a larger number-theoretic datapath. The channel runs as a linear pipeline of its own and does not exchange data with channels for other moduli. The caller presents all operand pairs of a vector on the same clock edge, one pair per lane. Each lane holds a data residue and a coefficient residue. An internal delay triangle skews lane k by k cycles, so that every lane meets its arithmetic stage in the cycle when the running sum arrives there.

Each stage forms the modular product of its pair in a single cycle with a computed look-up function indexed by the concatenated operand codes. It adds the product to the incoming partial sum with one conditional subtraction of the modulus. It registers every output bit and passes the sum and a valid flag on to the next stage. After TAPS cycles the last stage delivers the sum of all lane products modulo the modulus. Codes at or above the modulus are illegal. A lane that carries one contributes nothing to the sum.

Top module: `modmac_array`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, valid_o is 0 and sum_o is 0; the clear takes effect without waiting for a clock edge.
- R2: valid_o equals valid_i as it was sampled TAPS clock edges earlier.
- R3: When valid_o is 1, sum_o equals the sum over all lanes k of a_k*b_k, modulo MOD. The operands are those sampled together with the matching valid_i. Lane k occupies bits [k*W +: W] of a_i and b_i, with W = 2 for MOD 3 and W = 3 otherwise.
- R4: sum_o is always below MOD.
- R5: A lane whose a or b code is MOD or above contributes 0 to the sum. The other lanes of the same vector are unaffected.
- R6: When valid_o is 0, sum_o is 0. Operands presented with valid_i low leave no trace in later results.
- R7: Every legal pair (a, b) with both below MOD yields the product a*b mod MOD in every lane position.
- R8: Operand vectors can be accepted on consecutive cycles. Each one produces its own result TAPS cycles later, with no bubbles required between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand vector present this cycle |
| a_i | input | TAPS*W | Data residues, lane k at [k*W +: W] |
| b_i | input | TAPS*W | Coefficient residues, lane k at [k*W +: W] |
| valid_o | output | 1 | Result present this cycle |
| sum_o | output | W | Inner product modulo MOD |

## Verification
The checker relies on valid_i being a clean 0 or 1 on every edge after reset, and on reset being held for at least one rising clock edge. The operand buses may carry any code, so the range and idle-zero properties must hold even when illegal residues reach the lanes. The stimulus drives valid_i from a fixed-seed random stream and changes it only away from the clock edge. It mixes exhaustive legal pairs with occasional injected codes at or above the modulus, so the illegal-code path is reached without violating any input assumption.

// File: rtl/modmac_pkg.sv
package modmac_pkg;

  // Residue code width for a given modulus.
  function automatic int unsigned res_width(input int unsigned modulus);
    int unsigned w;
    w = 1;
    while ((1 << w) < modulus) w++;
    return w;
  endfunction

  // Table entry: product mod m, zero when either code is illegal.
  function automatic int unsigned mul_entry(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned modulus);
    if (a >= modulus || b >= modulus) return 0;
    return (a * b) % modulus;
  endfunction

endpackage

// File: rtl/modmac_mul_lut.sv
module modmac_mul_lut #(
  parameter int unsigned MOD = 7,
  parameter int unsigned W   = modmac_pkg::res_width(MOD)
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  localparam int unsigned IDX_W   = 2 * W;
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned MASK    = (1 << W) - 1;

  logic [W-1:0] tbl [ENTRIES];

  // Switching function built at elaboration; illegal codes map to zero.
  for (genvar idx = 0; idx < ENTRIES; idx++) begin : g_entry
    localparam int unsigned OP_A = idx >> W;
    localparam int unsigned OP_B = idx & MASK;
    assign tbl[idx] = W'(modmac_pkg::mul_entry(OP_A, OP_B, MOD));
  end

  assign p_o = tbl[{a_i, b_i}];

endmodule

// File: rtl/modmac_add.sv
module modmac_add #(
  parameter int unsigned MOD = 7,
  parameter int unsigned W   = modmac_pkg::res_width(MOD)
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  localparam logic [W:0] MODV = (W+1)'(MOD);

  logic [W:0] raw;
  logic [W:0] red;

  assign raw = {1'b0, x_i} + {1'b0, y_i};
  assign red = raw - MODV;
  assign s_o = (raw >= MODV) ? red[W-1:0] : raw[W-1:0];

endmodule

// File: rtl/modmac_skew.sv
module modmac_skew #(
  parameter int unsigned W     = 3,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_pass
    assign q_o = d_i;
  end else begin : g_delay
    logic [W-1:0] q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int j = 0; j < DEPTH; j++) q[j] <= '0;
      end else begin
        q[0] <= d_i;
        for (int j = 1; j < DEPTH; j++) q[j] <= q[j-1];
      end
    end
    assign q_o = q[DEPTH-1];
  end

endmodule

// File: rtl/modmac_stage.sv
module modmac_stage #(
  parameter int unsigned MOD = 7,
  parameter int unsigned W   = modmac_pkg::res_width(MOD)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] prod;
  logic [W-1:0] acc;

  modmac_mul_lut #(.MOD(MOD), .W(W)) i_mul (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (prod)
  );

  modmac_add #(.MOD(MOD), .W(W)) i_add (
    .x_i (sum_i),
    .y_i (prod),
    .s_o (acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
    end else begin
      valid_o <= valid_i;
      sum_o   <= valid_i ? acc : '0;
    end
  end

endmodule

// File: rtl/modmac_array.sv
module modmac_array #(
  parameter int unsigned MOD  = 7,
  parameter int unsigned TAPS = 4,
  parameter int unsigned W    = modmac_pkg::res_width(MOD)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [TAPS*W-1:0]   a_i,
  input  logic [TAPS*W-1:0]   b_i,
  output logic                valid_o,
  output logic [W-1:0]        sum_o
);
  logic [W-1:0] a_sk [TAPS];
  logic [W-1:0] b_sk [TAPS];
  logic [W-1:0] sum_c [TAPS+1];
  logic         vld_c [TAPS+1];

  assign sum_c[0] = '0;
  assign vld_c[0] = valid_i;

  for (genvar k = 0; k < TAPS; k++) begin : g_lane
    // Lane k waits k cycles so it meets the running sum at stage k.
    modmac_skew #(.W(2*W), .DEPTH(k)) i_skew (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({a_i[k*W +: W], b_i[k*W +: W]}),
      .q_o    ({a_sk[k], b_sk[k]})
    );

    modmac_stage #(.MOD(MOD), .W(W)) i_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (vld_c[k]),
      .sum_i   (sum_c[k]),
      .a_i     (a_sk[k]),
      .b_i     (b_sk[k]),
      .valid_o (vld_c[k+1]),
      .sum_o   (sum_c[k+1])
    );
  end

  assign valid_o = vld_c[TAPS];
  assign sum_o   = sum_c[TAPS];

endmodule

// File: rtl/modmac_array_chk.sv
module modmac_array_chk #(
  parameter int unsigned MOD  = 7,
  parameter int unsigned TAPS = 4,
  parameter int unsigned W    = modmac_pkg::res_width(MOD)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         valid_o,
  input logic [W-1:0] sum_o
);
  localparam int unsigned CNT_W = $clog2(TAPS + 1) + 1;

  logic [TAPS-1:0]  vld_hist;
  logic [CNT_W-1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_hist  <= '0;
      since_rst <= '0;
    end else begin
      vld_hist <= {vld_hist[TAPS-2:0], valid_i};
      if (since_rst < CNT_W'(TAPS)) since_rst <= since_rst + 1'b1;
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!valid_o && sum_o == '0)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= CNT_W'(TAPS)) |-> (valid_o == vld_hist[TAPS-1])); // R2

  AST_SUM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_o < W'(MOD)); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (sum_o == '0)); // R6

endmodule

bind modmac_array modmac_array_chk #(.MOD(MOD), .TAPS(TAPS), .W(W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .sum_o   (sum_o)
);

// File: tb/test_modmac_array.sv
`timescale 1ns/1ps
module test_modmac_array;
  localparam int unsigned MOD  = 7;
  localparam int unsigned TAPS = 4;
  localparam int unsigned W    = 3;
  localparam int unsigned HIST = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [TAPS*W-1:0] a_i = '0;
  logic [TAPS*W-1:0] b_i = '0;
  logic              valid_o;
  logic [W-1:0]      sum_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int seed_v;

  logic        h_vld [HIST];
  int          h_sum [HIST];
  string       h_tag [HIST];

  always #2.5 clk_i = ~clk_i;

  modmac_array #(.MOD(MOD), .TAPS(TAPS)) i_modmac_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .valid_o (valid_o),
    .sum_o   (sum_o)
  );

  function automatic int lane_prod(int a, int b);
    if (a >= MOD || b >= MOD) return 0; // R5
    return (a * b) % MOD;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < HIST; i++) begin
      h_vld[i] = 1'b0;
      h_sum[i] = 0;
      h_tag[i] = "R6";
    end
    cyc = 0;
  endtask

  // One cycle: check the result due now, then drive a new vector.
  task automatic step(bit v, int av[TAPS], int bv[TAPS], string tag);
    int slot;
    int s;
    @(negedge clk_i);
    slot = (cyc + HIST - TAPS) % HIST;
    check(valid_o == h_vld[slot], "R2", int'(valid_o), int'(h_vld[slot]));
    check(sum_o < MOD, "R4", int'(sum_o), MOD - 1);
    if (h_vld[slot])
      check(int'(sum_o) == h_sum[slot], h_tag[slot], int'(sum_o), h_sum[slot]);
    else
      check(sum_o == '0, "R6", int'(sum_o), 0);
    s = 0;
    for (int k = 0; k < TAPS; k++) begin
      a_i[k*W +: W] = W'(av[k]);
      b_i[k*W +: W] = W'(bv[k]);
      s = (s + lane_prod(av[k], bv[k])) % MOD;
    end
    valid_i = v;
    slot = cyc % HIST;
    h_vld[slot] = v;
    h_sum[slot] = s;
    h_tag[slot] = tag;
    cyc++;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int av[TAPS];
    int bv[TAPS];
    seed_v = $urandom(32'h5eed_0017);
    clear_hist();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(valid_o == 1'b0, "R1", int'(valid_o), 0);
    check(sum_o == '0, "R1", int'(sum_o), 0);
    rst_ni = 1'b1;
    check(valid_o == 1'b0 && sum_o == '0, "R1", int'(sum_o), 0);

    // R7: every legal pair, rotated over lane positions, back to back (R8).
    for (int a = 0; a < MOD; a++) begin
      for (int b = 0; b < MOD; b++) begin
        for (int k = 0; k < TAPS; k++) begin
          av[k] = 0;
          bv[k] = 0;
        end
        av[(a * MOD + b) % TAPS] = a;
        bv[(a * MOD + b) % TAPS] = b;
        step(1'b1, av, bv, "R7");
      end
    end

    // Directed: all maximum residues, R3.
    for (int k = 0; k < TAPS; k++) begin av[k] = MOD - 1; bv[k] = MOD - 1; end
    step(1'b1, av, bv, "R3");
    // Directed: illegal code in every lane gives zero, R5.
    for (int k = 0; k < TAPS; k++) begin av[k] = 7; bv[k] = 3; end
    step(1'b1, av, bv, "R5");
    // Directed: illegal code in one lane only, R5.
    for (int k = 0; k < TAPS; k++) begin av[k] = 2; bv[k] = 3; end
    bv[1] = 7;
    step(1'b1, av, bv, "R5");
    // Directed: invalid vector with large operands leaves no trace, R6.
    for (int k = 0; k < TAPS; k++) begin av[k] = 5; bv[k] = 6; end
    step(1'b0, av, bv, "R6");
    for (int k = 0; k < TAPS; k++) begin av[k] = 1; bv[k] = 1; end
    step(1'b1, av, bv, "R3");

    // Random traffic with occasional illegal codes.
    for (int n = 0; n < 400; n++) begin
      bit ill;
      ill = ($urandom_range(7) == 0);
      for (int k = 0; k < TAPS; k++) begin
        av[k] = $urandom_range(MOD - 1);
        bv[k] = $urandom_range(MOD - 1);
      end
      if (ill) av[$urandom_range(TAPS - 1)] = $urandom_range(7, MOD);
      step($urandom_range(3) != 0, av, bv, ill ? "R5" : "R3");
    end

    // Reset in flight clears outputs at once, R1.
    for (int k = 0; k < TAPS; k++) begin av[k] = 3; bv[k] = 4; end
    step(1'b1, av, bv, "R3");
    step(1'b1, av, bv, "R3");
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(valid_o == 1'b0, "R1", int'(valid_o), 0);
    check(sum_o == '0, "R1", int'(sum_o), 0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    clear_hist();
    for (int n = 0; n < 2 * TAPS; n++) begin
      for (int k = 0; k < TAPS; k++) begin
        av[k] = $urandom_range(MOD - 1);
        bv[k] = $urandom_range(MOD - 1);
      end
      step(1'b1, av, bv, "R3");
    end
    for (int n = 0; n < TAPS + 1; n++) step(1'b0, av, bv, "R6");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule